// File: doc/BRIEF.md
# Measurement Epoch and Interrupt Timer

This block derives two periodic events from a sample-rate clock enable. The short one marks the end of each accumulation interval and raises the accumulation interrupt. The long one is the measurement epoch. It gives the channel logic a one-clock epoch strobe and raises the measurement interrupt in the same clock. Both periods are counted in clock-enable pulses, and software sets them through a small address/data register port. After reset both periods come from a synthesis parameter that gives the enable rate, so the block starts with an accumulation interval of about 505.05 µs and an epoch of 50 ms.

Software can work in two ways. An interrupt-driven handler reads the status register on each measurement interrupt. A polling loop reads the same register on every accumulation interrupt and tests the epoch bit to see whether fresh measurement data has been captured. Both status bits are sticky and are cleared by reading the status register. A bit that gets a new event in the same clock as the read stays set.

The epoch period is 32 bits wide and is written as two 16-bit halves. A two-state machine manages the change of period. In state `PER_RUN`, the counter reloads from the active period. The "commit" transition (a write of the low half) moves the machine to `PER_PENDING`. A further commit while pending stays in `PER_PENDING` and replaces the staged value. The "boundary" transition (an epoch event with no commit in the same clock) copies the staged value into the active period and returns to `PER_RUN`. The interval that starts at that boundary already uses the new value.

Top module: `epoch_irq_timer`

## Requirements
- R1: With enable rate F, the reset values are as follows. The accumulation period (address 0) is round(F × 505.05 µs). The epoch period is F/20, shown with its upper 16 bits at address 1 and its lower 16 bits at address 2. For F = 198000 these are 100 and 9900.
- R2: An accumulation event occurs on every P-th enable pulse, where P is the value at address 0. A write to address 0 takes effect at the next accumulation boundary. P = 0 behaves as P = 1.
- R3: A write to address 1 stages the upper half of the epoch period. A write to address 2 commits {upper, written lower} as the new period and sets the pending flag (status bit 2). At the next epoch boundary the new period starts and bit 2 clears.
- R4: `tic_strobe` is high for exactly the one clock that follows the edge at which the enable pulse closing an epoch was sampled.
- R5: Status bit 0 (epoch) is set by each epoch event. It is cleared by a read of address 3 (`rd_en` high) unless an epoch event occurs in the same clock, in which case it stays set.
- R6: Status bit 1 (accumulation) is set by each accumulation event and clears on a status read under the same rule as R5.
- R7: `irq_meas` follows status bit 0 and `irq_accum` follows status bit 1. Both are inverted when bit 0 of a write to address 3 is 1 (active-low mode). That mode bit reads back at status bit 15.
- R8: In reset the status bits, the strobe and the interrupts are inactive, and both counters restart a full period.
- R9: The counters advance only on clocks where `sample_ce` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_ce | input | 1 | Sample-rate enable, one pulse per sample |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe (a read of address 3 clears the sticky bits) |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| tic_strobe | output | 1 | One-clock epoch strobe |
| irq_meas | output | 1 | Measurement interrupt |
| irq_accum | output | 1 | Accumulation interrupt |

## Verification
Suppose the enable pulse that closes a period is sampled at edge k. Then the strobe, both status bits and both interrupts change just after edge k, so they are visible one clock after that pulse was driven. `rd_data` is combinational and is valid in the same clock as the address. A status-clearing read takes effect at the next edge. A register write is visible after the next edge, but a new period takes effect only from the boundary that follows. The bench drives inputs at the falling edge and checks every output against its own model at the next falling edge. Directed reads are sampled shortly after a falling edge, so every check lands exactly one register stage after its stimulus.

// File: rtl/epoch_pkg.sv
package epoch_pkg;
    typedef enum logic {
        PER_RUN,
        PER_PENDING
    } per_state_e;

    localparam logic [1:0] ADDR_ACC    = 2'd0;
    localparam logic [1:0] ADDR_TIC_HI = 2'd1;
    localparam logic [1:0] ADDR_TIC_LO = 2'd2;
    localparam logic [1:0] ADDR_STAT   = 2'd3;
endpackage

// File: rtl/period_counter.sv
module period_counter #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] RST_PERIOD = W'(1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic [W-1:0] period,
    output logic         fire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;
    logic [W-1:0] reload;

    // a zero period is clamped to one enable pulse
    always_comb begin
        reload = (period == '0) ? '0 : period - ONE;
    end

    assign fire = ce && (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= (RST_PERIOD == '0) ? '0 : RST_PERIOD - ONE;
        end else if (ce) begin
            cnt <= (cnt == '0) ? reload : cnt - ONE;
        end
    end

    assert_hold_without_ce_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(cnt));
endmodule

// File: rtl/tic_period_ctrl.sv
module tic_period_ctrl
    import epoch_pkg::*;
#(
    parameter int unsigned HALF_W = 16,
    parameter logic [2*HALF_W-1:0] RST_PERIOD = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_hi,
    input  logic                wr_lo,
    input  logic [HALF_W-1:0]   wr_data,
    input  logic                tic_fire,
    output logic [2*HALF_W-1:0] eff_period,
    output logic [HALF_W-1:0]   staged_hi,
    output logic [HALF_W-1:0]   staged_lo,
    output logic                pending
);
    localparam int unsigned FULL_W = 2 * HALF_W;

    per_state_e state_q, state_d;
    logic [FULL_W-1:0] active_q;
    logic [FULL_W-1:0] pend_q;
    logic [HALF_W-1:0] hi_q;
    logic [HALF_W-1:0] lo_q;
    logic              boundary;

    assign boundary = tic_fire && !wr_lo;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PER_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PER_RUN:     if (wr_lo) state_d = PER_PENDING;
            PER_PENDING: if (boundary) state_d = PER_RUN;
            default:     state_d = PER_RUN;
        endcase
    end

    // outputs
    always_comb begin
        eff_period = active_q;
        pending    = 1'b0;
        unique case (state_q)
            PER_RUN: begin
                eff_period = active_q;
                pending    = 1'b0;
            end
            PER_PENDING: begin
                eff_period = pend_q;
                pending    = 1'b1;
            end
            default: begin
                eff_period = active_q;
                pending    = 1'b0;
            end
        endcase
    end

    assign staged_hi = hi_q;
    assign staged_lo = lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q     <= RST_PERIOD[FULL_W-1:HALF_W];
            lo_q     <= RST_PERIOD[HALF_W-1:0];
            pend_q   <= RST_PERIOD;
            active_q <= RST_PERIOD;
        end else begin
            if (wr_hi) hi_q <= wr_data;
            if (wr_lo) begin
                lo_q   <= wr_data;
                pend_q <= {hi_q, wr_data};
            end
            if (state_q == PER_PENDING && boundary) active_q <= pend_q;
        end
    end

    assert_commit_pends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (state_q == PER_PENDING));
    assert_boundary_applies_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PER_PENDING && boundary) |=> (state_q == PER_RUN && active_q == $past(pend_q)));
endmodule

// File: rtl/status_irq.sv
module status_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic tic_fire,
    input  logic acc_fire,
    input  logic clr,
    input  logic pol_wr,
    input  logic pol_bit,
    output logic tic_flag,
    output logic acc_flag,
    output logic active_low,
    output logic tic_strobe,
    output logic irq_meas,
    output logic irq_accum
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tic_flag   <= 1'b0;
            acc_flag   <= 1'b0;
            active_low <= 1'b0;
            tic_strobe <= 1'b0;
        end else begin
            tic_flag   <= tic_fire || (tic_flag && !clr);
            acc_flag   <= acc_fire || (acc_flag && !clr);
            tic_strobe <= tic_fire;
            if (pol_wr) active_low <= pol_bit;
        end
    end

    assign irq_meas  = tic_flag ^ active_low;
    assign irq_accum = acc_flag ^ active_low;

    assert_tic_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tic_fire |=> tic_flag);
    assert_read_clears_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !acc_fire) |=> !acc_flag);
    assert_read_clears_tic_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !tic_fire) |=> !tic_flag);
    assert_strobe_with_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tic_strobe |-> (irq_meas != active_low));
endmodule

// File: rtl/epoch_irq_timer.sv
module epoch_irq_timer
    import epoch_pkg::*;
#(
    parameter int unsigned SAMPLE_HZ = 1980000,
    parameter int unsigned DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_ce,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              tic_strobe,
    output logic              irq_meas,
    output logic              irq_accum
);
    localparam int unsigned TIC_W = 2 * DATA_W;
    // 505.05 us = 10101 / 20e6 s, rounded to nearest count
    localparam logic [63:0] ACC_DEF64 =
        (64'(SAMPLE_HZ) * 64'd10101 + 64'd10000000) / 64'd20000000;
    // 50 ms = 1/20 s
    localparam logic [63:0] TIC_DEF64 = 64'(SAMPLE_HZ) / 64'd20;
    localparam logic [DATA_W-1:0] ACC_DEF = ACC_DEF64[DATA_W-1:0];
    localparam logic [TIC_W-1:0]  TIC_DEF = TIC_DEF64[TIC_W-1:0];

    logic [DATA_W-1:0] acc_period_q;
    logic              acc_fire, tic_fire;
    logic [TIC_W-1:0]  tic_eff;
    logic [DATA_W-1:0] tic_hi, tic_lo;
    logic              tic_pending;
    logic              tic_flag, acc_flag, active_low;
    logic              wr_acc, wr_hi, wr_lo, wr_ctl, stat_rd;

    assign wr_acc  = wr_en && (wr_addr == ADDR_ACC);
    assign wr_hi   = wr_en && (wr_addr == ADDR_TIC_HI);
    assign wr_lo   = wr_en && (wr_addr == ADDR_TIC_LO);
    assign wr_ctl  = wr_en && (wr_addr == ADDR_STAT);
    assign stat_rd = rd_en && (rd_addr == ADDR_STAT);

    always_ff @(posedge clk) begin
        if (!rst_n)      acc_period_q <= ACC_DEF;
        else if (wr_acc) acc_period_q <= wr_data;
    end

    period_counter #(.W(DATA_W), .RST_PERIOD(ACC_DEF)) u_acc_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce     (sample_ce),
        .period (acc_period_q),
        .fire   (acc_fire)
    );

    period_counter #(.W(TIC_W), .RST_PERIOD(TIC_DEF)) u_tic_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce     (sample_ce),
        .period (tic_eff),
        .fire   (tic_fire)
    );

    tic_period_ctrl #(.HALF_W(DATA_W), .RST_PERIOD(TIC_DEF)) u_tic_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hi      (wr_hi),
        .wr_lo      (wr_lo),
        .wr_data    (wr_data),
        .tic_fire   (tic_fire),
        .eff_period (tic_eff),
        .staged_hi  (tic_hi),
        .staged_lo  (tic_lo),
        .pending    (tic_pending)
    );

    status_irq u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .tic_fire   (tic_fire),
        .acc_fire   (acc_fire),
        .clr        (stat_rd),
        .pol_wr     (wr_ctl),
        .pol_bit    (wr_data[0]),
        .tic_flag   (tic_flag),
        .acc_flag   (acc_flag),
        .active_low (active_low),
        .tic_strobe (tic_strobe),
        .irq_meas   (irq_meas),
        .irq_accum  (irq_accum)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_ACC:    rd_data = acc_period_q;
            ADDR_TIC_HI: rd_data = tic_hi;
            ADDR_TIC_LO: rd_data = tic_lo;
            ADDR_STAT: begin
                rd_data            = '0;
                rd_data[0]         = tic_flag;
                rd_data[1]         = acc_flag;
                rd_data[2]         = tic_pending;
                rd_data[DATA_W-1]  = active_low;
            end
            default:     rd_data = '0;
        endcase
    end

    assert_reset_quiet_R8: assert property (@(posedge clk)
        !rst_n |=> (!tic_strobe && !tic_flag && !acc_flag));
endmodule

// File: tb/sim_epoch_irq_timer.sv
module sim_epoch_irq_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_ce = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        tic_strobe, irq_meas, irq_accum;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    longint m_acc_per, m_hi, m_lo, m_act, m_pend_per, m_acc_cnt, m_tic, eff;
    bit     m_pend, m_tf, m_af, m_pol, m_strobe, fa, ft, clr;

    always #5 clk = ~clk;

    epoch_irq_timer #(.SAMPLE_HZ(198000), .DATA_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_ce(sample_ce),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .tic_strobe(tic_strobe), .irq_meas(irq_meas), .irq_accum(irq_accum)
    );

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_acc_per = 100; m_hi = 0; m_lo = 9900; m_act = 9900; m_pend_per = 9900;
            m_pend = 0; m_acc_cnt = 99; m_tic = 9899;
            m_tf = 0; m_af = 0; m_pol = 0; m_strobe = 0;
        end else begin
            fa = sample_ce && m_acc_cnt == 0;
            ft = sample_ce && m_tic == 0;
            if (sample_ce) m_acc_cnt = fa ? ((m_acc_per == 0) ? 0 : m_acc_per - 1) : m_acc_cnt - 1;
            eff = m_pend ? m_pend_per : m_act;
            if (sample_ce) m_tic = ft ? ((eff == 0) ? 0 : eff - 1) : m_tic - 1;
            clr = rd_en && rd_addr == 2'd3;
            m_tf = ft || (m_tf && !clr);
            m_af = fa || (m_af && !clr);
            m_strobe = ft;
            if (ft && m_pend && !(wr_en && wr_addr == 2'd2)) begin
                m_act = m_pend_per; m_pend = 0;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_acc_per = wr_data;
                    2'd1: m_hi = wr_data;
                    2'd2: begin m_lo = wr_data; m_pend_per = m_hi * 65536 + wr_data; m_pend = 1; end
                    default: m_pol = wr_data[0];
                endcase
            end
        end
    end

    function automatic logic [15:0] model_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_acc_per[15:0];
            2'd1: return m_hi[15:0];
            2'd2: return m_lo[15:0];
            default: return {m_pol, 12'd0, m_pend, m_af, m_tf};
        endcase
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    // one clock: edge, then compare all outputs against the model
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        if (rst_n) begin
            check("R4 strobe", tic_strobe, m_strobe);
            check("R7 irq_meas", irq_meas, m_tf ^ m_pol);
            check("R7 irq_accum", irq_accum, m_af ^ m_pol);
            check("R5 rd_data", rd_data, model_rd(rd_addr));
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        cyc();
        rd_en = 1'b0; rd_addr = 2'd0;
    endtask

    initial begin
        logic [15:0] v;
        int n;
        repeat (3) cyc();
        check("R8 strobe in reset", tic_strobe, 0);
        check("R8 irq in reset", irq_meas | irq_accum, 0);
        rst_n = 1'b1;
        rd(2'd3, v); check("R8 status after reset", v, 0);
        rd(2'd0, v); check("R1 default accum period", v, 100);
        rd(2'd1, v); check("R1 default epoch high", v, 0);
        rd(2'd2, v); check("R1 default epoch low", v, 9900);

        // default periods with a continuous enable
        sample_ce = 1'b1;
        n = 0;
        while (!irq_accum && n < 200) begin cyc(); n++; end
        check("R2 first accum event after 100 pulses", n, 100);
        while (!tic_strobe && n < 12000) begin cyc(); n++; end
        check("R1 first epoch after 9900 pulses", n, 9900);
        cyc();
        check("R4 strobe lasts one clock", tic_strobe, 0);
        check("R5 epoch flag held", irq_meas, 1);
        rd(2'd3, v);
        check("R5 status epoch bit", v[0], 1);
        check("R6 status accum bit", v[1], 1);
        rd(2'd3, v);
        check("R6 cleared by read", v[1:0], 0);

        // program new periods
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd40);
        rd(2'd3, v); check("R3 pending after commit", v[2], 1);
        wr(2'd0, 16'd5);
        n = 0;
        while (!tic_strobe && n < 12000) begin cyc(); n++; end
        rd(2'd3, v); check("R3 pending cleared at boundary", v[2], 0);
        n = 1;
        while (!tic_strobe && n < 200) begin cyc(); n++; end
        check("R3 new epoch period 40", n, 40);

        // gapped enable: one pulse in three
        n = 0;
        for (int i = 0; i < 400; i++) begin
            sample_ce = (i % 3 == 0);
            cyc();
            if (tic_strobe) break;
        end
        n = 0;
        for (int i = 0; i < 400; i++) begin
            sample_ce = (i % 3 == 0);
            if (sample_ce) n++;
            cyc();
            if (tic_strobe) break;
        end
        check("R9 only enabled clocks count", n, 40);

        // status read in the same clock as an epoch event
        sample_ce = 1'b1;
        while (m_tic != 5) cyc();
        rd(2'd3, v);
        while (m_tic != 0) cyc();
        rd_en = 1'b1; rd_addr = 2'd3;
        cyc();
        rd_en = 1'b0;
        check("R5 flag kept when read meets epoch", irq_meas, 1);

        // active-low interrupts
        sample_ce = 1'b0;
        wr(2'd3, 16'd1);
        rd(2'd3, v);
        check("R7 mode bit reads back", v[15], 1);
        check("R7 idle active-low meas", irq_meas, 1);
        check("R7 idle active-low accum", irq_accum, 1);

        // accumulation period zero acts as one
        wr(2'd0, 16'd0);
        sample_ce = 1'b1;
        repeat (6) cyc();
        for (int i = 0; i < 5; i++) begin
            rd(2'd3, v);
            check("R2 zero period fires every pulse", v[1], 1);
        end
        sample_ce = 1'b0;
        repeat (3) cyc();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule